// File: doc/BRIEF.md
# Legacy I/O Configuration Controller

This block holds the configuration state of a legacy peripheral I/O device and turns it into the resource settings used by the peripherals attached to it. It sits on a plain I/O bus with a 16-bit address, 8-bit data, and separate read and write strobes. Two adjacent ports carry the configuration traffic: an index port at 0x3F0 and a data port at 0x3F1.

Configuration is locked after reset. Host software unlocks it by writing a two-step key to the index port. While unlocked, software picks one of sixteen 8-bit configuration registers through the index port and reads or writes it through the data port. A separate key written to the index port locks the block again.

The block decodes the register contents all the time. From them it produces, for two serial ports, one parallel port, a floppy controller and an IDE channel, an enable flag, a base address and an interrupt number. These outputs are registered.

Top module: `legacy_io_cfg`

## Requirements
- R1: After reset the block is locked. Registers 0, 1 and 2 hold 0x3F, 0x9F and 0xDC, and registers 3 to 15 hold 0x00. The derived outputs are then: serial A on at 0x3F8 with IRQ 4, serial B on at 0x2F8 with IRQ 3, parallel on at 0x278 with IRQ 7, floppy on at 0x3F0, and IDE on at 0x1F0 with control port 0x3F6.
- R2: While locked, each write of 0x55 to 0x3F0 raises the unlock count by one. Configuration mode starts when the count reaches 2. Any other locked write, including a write of 0x55 to 0x3F1, leaves the count unchanged.
- R3: While unlocked, a write of 0xAA to 0x3F0 locks the block and clears the count, so two more 0x55 writes are needed to unlock it again.
- R4: While unlocked, any other value written to 0x3F0 becomes the index. A data-port write with an index above 15 changes no register.
- R5: A read of 0x3F1 with ioRd high returns the indexed register only while unlocked and only with an index of 15 or less. Every other case returns 0x00: a locked read, a read of 0x3F0, an out-of-range index, or ioRd low.
- R6: Data-port writes while locked change no register.
- R7: Register 1 bits 6:5 choose the alternate address pair (alt3/alt4): 00 gives 0x338/0x238, 01 gives 0x3E8/0x2E8, 10 gives 0x3E8/0x2E0, 11 gives 0x220/0x228.
- R8: Register 2 controls both serial ports. For port A, bit 2 is the enable and bits 1:0 are the select. For port B, bit 6 is the enable and bits 5:4 are the select. The select values decode as follows: 0 gives 0x3F8 with IRQ 4, 1 gives 0x2F8 with IRQ 3, 2 gives alt3 with IRQ 4, and 3 gives alt4 with IRQ 3. The base and IRQ follow the select whether or not the port is enabled.
- R9: Register 1 bits 1:0 control the parallel port. A value of 0 disables it and sets its base to 0x0000. Values 1, 2 and 3 give 0x3BC, 0x378 and 0x278. The parallel IRQ is always 7.
- R10: Register 0 bit 4 enables the floppy controller, whose base is fixed at 0x3F0. Register 0 bit 0 enables the IDE channel, whose base is fixed at 0x1F0 with control port 0x3F6.
- R11: Every derived output changes on the first clock edge after the edge that writes the register it comes from.
- R12: If a data-port read and a data-port write happen in the same cycle, the read returns the value the register held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ioAddr | input | 16 | I/O address |
| ioWrData | input | 8 | Write data |
| ioWr | input | 1 | Write strobe, one cycle per write |
| ioRd | input | 1 | Read strobe |
| ioRdData | output | 8 | Read data, combinational |
| serAEn | output | 1 | Serial A enable |
| serABase | output | 16 | Serial A base address |
| serAIrq | output | 4 | Serial A IRQ |
| serBEn | output | 1 | Serial B enable |
| serBBase | output | 16 | Serial B base address |
| serBIrq | output | 4 | Serial B IRQ |
| parEn | output | 1 | Parallel enable |
| parBase | output | 16 | Parallel base address |
| parIrq | output | 4 | Parallel IRQ |
| fdcEn | output | 1 | Floppy controller enable |
| fdcBase | output | 16 | Floppy controller base |
| ideEn | output | 1 | IDE enable |
| ideBase | output | 16 | IDE command block base |
| ideCtlBase | output | 16 | IDE control port |

## Verification
Two things can fall in the same cycle: a data-port read and a data-port write to the same register. The bench provokes this by raising ioRd and ioWr together on 0x3F1 and checking that the read returns the value held before the write. A plain read in the next cycle must then return the new value. Register writes also overlap with the one-cycle lag of the derived outputs. The reference model compares every output on every clock, so an output that updates on the write edge itself, rather than one edge later, is caught.

// File: rtl/legacy_cfg_pkg.sv
package legacy_cfg_pkg;
  localparam int NUM_REGS = 16;
  localparam int IDX_W    = $clog2(NUM_REGS);

  localparam logic [15:0] SER_PRI_BASE = 16'h03F8;
  localparam logic [15:0] SER_SEC_BASE = 16'h02F8;
  localparam logic [15:0] FDC_BASE     = 16'h03F0;
  localparam logic [15:0] IDE_BASE     = 16'h01F0;
  localparam logic [15:0] IDE_CTL_BASE = 16'h03F6;
  localparam logic [3:0]  PAR_IRQ      = 4'd7;

  // Strobes from control to datapath
  typedef struct packed {
    logic             regWr;
    logic [IDX_W-1:0] regIdx;
    logic             idxInRange;
    logic             cfgActive;
  } cfgStrobe_t;

  function automatic logic [7:0] regResetVal(input int i);
    case (i)
      0:       return 8'h3F;
      1:       return 8'h9F;
      2:       return 8'hDC;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/legacy_io_cfg_ctrl.sv
module legacy_io_cfg_ctrl
  import legacy_cfg_pkg::*;
#(
  parameter int              ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] INDEX_PORT = 16'h03F0,
  parameter logic [7:0]      KEY_ENTER  = 8'h55,
  parameter logic [7:0]      KEY_EXIT   = 8'hAA,
  parameter int              UNLOCK_CNT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic [7:0]        ioWrData,
  input  logic              ioWr,
  output cfgStrobe_t        strb
);
  localparam int CNT_W = $clog2(UNLOCK_CNT + 1);
  localparam logic [ADDR_W-1:0] DATA_PORT = INDEX_PORT + 1'b1;

  logic [CNT_W-1:0] unlockCnt;
  logic [7:0]       indexReg;
  logic             active;
  logic             hitIdx;
  logic             hitData;

  assign active  = (unlockCnt == CNT_W'(UNLOCK_CNT));
  assign hitIdx  = ioWr && (ioAddr == INDEX_PORT);
  assign hitData = ioWr && (ioAddr == DATA_PORT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      unlockCnt <= '0;
      indexReg  <= '0;
    end else if (hitIdx) begin
      if (active) begin
        if (ioWrData == KEY_EXIT) unlockCnt <= '0;
        else                      indexReg  <= ioWrData;
      end else if (ioWrData == KEY_ENTER) begin
        unlockCnt <= unlockCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strb.cfgActive  = active;
    strb.idxInRange = (indexReg < 8'(NUM_REGS));
    strb.regIdx     = indexReg[IDX_W-1:0];
    strb.regWr      = hitData && active && (indexReg < 8'(NUM_REGS));
  end

  // R2
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!active && ioWr && !(hitIdx && ioWrData == KEY_ENTER)) |=> $stable(unlockCnt));
  // R3
  exit_key_chk: assert property (@(posedge clk) disable iff (!rstN)
    (active && hitIdx && ioWrData == KEY_EXIT) |=> (!strb.cfgActive && unlockCnt == '0));
  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    unlockCnt <= CNT_W'(UNLOCK_CNT));
endmodule

// File: rtl/legacy_io_cfg_dp.sv
module legacy_io_cfg_dp
  import legacy_cfg_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] DATA_PORT = 16'h03F1
) (
  input  logic              clk,
  input  logic              rstN,
  input  cfgStrobe_t        strb,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic [7:0]        ioWrData,
  input  logic              ioRd,
  output logic [7:0]        ioRdData,
  output logic [1:0]        serEn,
  output logic [1:0][15:0]  serBase,
  output logic [1:0][3:0]   serIrq,
  output logic              parEn,
  output logic [15:0]       parBase,
  output logic [3:0]        parIrq,
  output logic              fdcEn,
  output logic [15:0]       fdcBase,
  output logic              ideEn,
  output logic [15:0]       ideBase,
  output logic [15:0]       ideCtlBase
);
  localparam int SER_PORTS = 2;
  localparam int SER_FIELD = 4;

  logic [NUM_REGS-1:0][7:0] regFile;
  logic [15:0] alt3Addr, alt4Addr;

  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        regFile[gi] <= regResetVal(gi);
      else if (strb.regWr && strb.regIdx == IDX_W'(gi))
        regFile[gi] <= ioWrData;
    end
  end

  assign ioRdData = (ioRd && ioAddr == DATA_PORT && strb.cfgActive && strb.idxInRange)
                    ? regFile[strb.regIdx] : 8'h00;

  always_comb begin
    case (regFile[1][6:5])
      2'd0: begin alt3Addr = 16'h0338; alt4Addr = 16'h0238; end
      2'd1: begin alt3Addr = 16'h03E8; alt4Addr = 16'h02E8; end
      2'd2: begin alt3Addr = 16'h03E8; alt4Addr = 16'h02E0; end
      default: begin alt3Addr = 16'h0220; alt4Addr = 16'h0228; end
    endcase
  end

  for (genvar gs = 0; gs < SER_PORTS; gs++) begin : g_ser
    logic [2:0]  field;
    logic [15:0] baseNext;
    logic [3:0]  irqNext;
    assign field = regFile[2][gs*SER_FIELD +: 3];
    always_comb begin
      case (field[1:0])
        2'd0:    begin baseNext = SER_PRI_BASE; irqNext = 4'd4; end
        2'd1:    begin baseNext = SER_SEC_BASE; irqNext = 4'd3; end
        2'd2:    begin baseNext = alt3Addr;     irqNext = 4'd4; end
        default: begin baseNext = alt4Addr;     irqNext = 4'd3; end
      endcase
    end
    always_ff @(posedge clk) begin
      serEn[gs]   <= field[2];
      serBase[gs] <= baseNext;
      serIrq[gs]  <= irqNext;
    end
  end

  always_ff @(posedge clk) begin
    parEn <= (regFile[1][1:0] != 2'd0);
    case (regFile[1][1:0])
      2'd1:    parBase <= 16'h03BC;
      2'd2:    parBase <= 16'h0378;
      2'd3:    parBase <= 16'h0278;
      default: parBase <= 16'h0000;
    endcase
    parIrq     <= PAR_IRQ;
    fdcEn      <= regFile[0][4];
    fdcBase    <= FDC_BASE;
    ideEn      <= regFile[0][0];
    ideBase    <= IDE_BASE;
    ideCtlBase <= IDE_CTL_BASE;
  end

  // R4
  no_stray_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.regWr |=> $stable(regFile));
  // R6
  locked_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.cfgActive |-> !strb.regWr);
  // R5
  locked_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.cfgActive |-> ioRdData == 8'h00);
  // R11
  ser_lag_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> serEn[0] == $past(regFile[2][2]));
  // R11
  fdc_lag_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> fdcEn == $past(regFile[0][4]));
endmodule

// File: rtl/legacy_io_cfg.sv
module legacy_io_cfg
  import legacy_cfg_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic [7:0]        ioWrData,
  input  logic              ioWr,
  input  logic              ioRd,
  output logic [7:0]        ioRdData,
  output logic              serAEn,
  output logic [15:0]       serABase,
  output logic [3:0]        serAIrq,
  output logic              serBEn,
  output logic [15:0]       serBBase,
  output logic [3:0]        serBIrq,
  output logic              parEn,
  output logic [15:0]       parBase,
  output logic [3:0]        parIrq,
  output logic              fdcEn,
  output logic [15:0]       fdcBase,
  output logic              ideEn,
  output logic [15:0]       ideBase,
  output logic [15:0]       ideCtlBase
);
  localparam logic [ADDR_W-1:0] IDX_PORT = ADDR_W'(16'h03F0);

  cfgStrobe_t       strb;
  logic [1:0]       serEn;
  logic [1:0][15:0] serBase;
  logic [1:0][3:0]  serIrq;

  legacy_io_cfg_ctrl #(.ADDR_W(ADDR_W), .INDEX_PORT(IDX_PORT)) i_ctrl (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWrData(ioWrData),
    .ioWr(ioWr), .strb(strb)
  );

  legacy_io_cfg_dp #(.ADDR_W(ADDR_W), .DATA_PORT(IDX_PORT + 1'b1)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .ioAddr(ioAddr), .ioWrData(ioWrData),
    .ioRd(ioRd), .ioRdData(ioRdData), .serEn(serEn), .serBase(serBase),
    .serIrq(serIrq), .parEn(parEn), .parBase(parBase), .parIrq(parIrq),
    .fdcEn(fdcEn), .fdcBase(fdcBase), .ideEn(ideEn), .ideBase(ideBase),
    .ideCtlBase(ideCtlBase)
  );

  assign serAEn   = serEn[0];
  assign serABase = serBase[0];
  assign serAIrq  = serIrq[0];
  assign serBEn   = serEn[1];
  assign serBBase = serBase[1];
  assign serBIrq  = serIrq[1];
endmodule

// File: tb/test_legacy_io_cfg.sv
module test_legacy_io_cfg;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] ioAddr = '0;
  logic [7:0]  ioWrData = '0;
  logic ioWr = 1'b0, ioRd = 1'b0;
  logic [7:0] ioRdData;
  logic serAEn, serBEn, parEn, fdcEn, ideEn;
  logic [15:0] serABase, serBBase, parBase, fdcBase, ideBase, ideCtlBase;
  logic [3:0] serAIrq, serBIrq, parIrq;

  int nChk = 0, nFail = 0;

  // reference model state
  logic [7:0] mRegs [16];
  int mCnt, mIdx;
  logic [15:0] eSerABase, eSerBBase, eParBase;
  logic [3:0]  eSerAIrq, eSerBIrq;
  logic eSerAEn, eSerBEn, eParEn, eFdcEn, eIdeEn;

  always #2.5 clk = ~clk;

  legacy_io_cfg i_legacy_io_cfg (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWrData(ioWrData), .ioWr(ioWr),
    .ioRd(ioRd), .ioRdData(ioRdData), .serAEn(serAEn), .serABase(serABase),
    .serAIrq(serAIrq), .serBEn(serBEn), .serBBase(serBBase), .serBIrq(serBIrq),
    .parEn(parEn), .parBase(parBase), .parIrq(parIrq), .fdcEn(fdcEn),
    .fdcBase(fdcBase), .ideEn(ideEn), .ideBase(ideBase), .ideCtlBase(ideCtlBase)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] altAddr(input logic [1:0] pair, input bit second);
    case (pair)
      2'd0: return second ? 16'h0238 : 16'h0338;
      2'd1: return second ? 16'h02E8 : 16'h03E8;
      2'd2: return second ? 16'h02E0 : 16'h03E8;
      default: return second ? 16'h0228 : 16'h0220;
    endcase
  endfunction

  function automatic logic [15:0] serBaseOf(input logic [1:0] sel, input logic [1:0] pair);
    if (sel == 0) return 16'h03F8;
    if (sel == 1) return 16'h02F8;
    return altAddr(pair, sel == 3);
  endfunction

  task automatic modelDecode();
    eSerAEn   = mRegs[2][2];
    eSerABase = serBaseOf(mRegs[2][1:0], mRegs[1][6:5]);
    eSerAIrq  = mRegs[2][0] ? 4'd3 : 4'd4;
    eSerBEn   = mRegs[2][6];
    eSerBBase = serBaseOf(mRegs[2][5:4], mRegs[1][6:5]);
    eSerBIrq  = mRegs[2][4] ? 4'd3 : 4'd4;
    eParEn    = mRegs[1][1:0] != 0;
    case (mRegs[1][1:0])
      2'd0: eParBase = 16'h0000;
      2'd1: eParBase = 16'h03BC;
      2'd2: eParBase = 16'h0378;
      default: eParBase = 16'h0278;
    endcase
    eFdcEn = mRegs[0][4];
    eIdeEn = mRegs[0][0];
  endtask

  task automatic modelReset();
    for (int i = 0; i < 16; i++) mRegs[i] = 8'h00;
    mRegs[0] = 8'h3F; mRegs[1] = 8'h9F; mRegs[2] = 8'hDC;
    mCnt = 0; mIdx = 0;
  endtask

  task automatic checkDerived();
    chk(serAEn == eSerAEn, "R8 R11 serAEn", 32'(serAEn), 32'(eSerAEn));
    chk(serABase == eSerABase, "R7 R8 R11 serABase", 32'(serABase), 32'(eSerABase));
    chk(serAIrq == eSerAIrq, "R8 serAIrq", 32'(serAIrq), 32'(eSerAIrq));
    chk(serBEn == eSerBEn, "R8 R11 serBEn", 32'(serBEn), 32'(eSerBEn));
    chk(serBBase == eSerBBase, "R7 R8 R11 serBBase", 32'(serBBase), 32'(eSerBBase));
    chk(serBIrq == eSerBIrq, "R8 serBIrq", 32'(serBIrq), 32'(eSerBIrq));
    chk(parEn == eParEn, "R9 R11 parEn", 32'(parEn), 32'(eParEn));
    chk(parBase == eParBase, "R9 R11 parBase", 32'(parBase), 32'(eParBase));
    chk(parIrq == 4'd7, "R9 parIrq", 32'(parIrq), 32'd7);
    chk(fdcEn == eFdcEn, "R10 R11 fdcEn", 32'(fdcEn), 32'(eFdcEn));
    chk(fdcBase == 16'h03F0, "R10 fdcBase", 32'(fdcBase), 32'h3F0);
    chk(ideEn == eIdeEn, "R10 R11 ideEn", 32'(ideEn), 32'(eIdeEn));
    chk(ideBase == 16'h01F0, "R10 ideBase", 32'(ideBase), 32'h1F0);
    chk(ideCtlBase == 16'h03F6, "R10 ideCtlBase", 32'(ideCtlBase), 32'h3F6);
  endtask

  // One bus cycle: drive at negedge, check read, model edge, check outputs
  task automatic cyc(input bit wr, input bit rd, input logic [15:0] a, input logic [7:0] d);
    logic [7:0] expRd;
    ioWr = wr; ioRd = rd; ioAddr = a; ioWrData = d;
    #1;
    expRd = (rd && a == 16'h03F1 && mCnt == 2 && mIdx < 16) ? mRegs[mIdx] : 8'h00;
    chk(ioRdData == expRd, (wr && rd) ? "R12 rdData" : "R5 rdData", 32'(ioRdData), 32'(expRd));
    @(posedge clk);
    modelDecode();
    if (wr && a == 16'h03F0) begin
      if (mCnt == 2) begin
        if (d == 8'hAA) mCnt = 0; else mIdx = int'(d);
      end else if (d == 8'h55) mCnt++;
    end else if (wr && a == 16'h03F1 && mCnt == 2 && mIdx < 16) begin
      mRegs[mIdx] = d;
    end
    @(negedge clk);
    checkDerived();
    ioWr = 1'b0; ioRd = 1'b0;
  endtask

  task automatic wrIdx(input logic [7:0] d); cyc(1, 0, 16'h03F0, d); endtask
  task automatic wrDat(input logic [7:0] d); cyc(1, 0, 16'h03F1, d); endtask
  task automatic rdDat(output logic [7:0] v);
    ioWr = 0; ioRd = 1; ioAddr = 16'h03F1; #1; v = ioRdData;
    cyc(0, 1, 16'h03F1, 8'h00);
  endtask
  task automatic idle(); cyc(0, 0, 16'h0000, 8'h00); endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] v;
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state at the outputs
    chk(serAEn && serABase == 16'h03F8 && serAIrq == 4'd4, "R1 serA", 32'(serABase), 32'h3F8);
    chk(serBEn && serBBase == 16'h02F8 && serBIrq == 4'd3, "R1 serB", 32'(serBBase), 32'h2F8);
    chk(parEn && parBase == 16'h0278 && parIrq == 4'd7, "R1 par", 32'(parBase), 32'h278);
    chk(fdcEn && ideEn, "R1 fdc ide", 32'({fdcEn, ideEn}), 32'h3);

    // R5 / R6: locked accesses
    rdDat(v); chk(v == 8'h00, "R5 locked read", 32'(v), 0);
    wrDat(8'h00);
    // R2: partial key, stray values, wrong port
    wrIdx(8'h55);
    wrIdx(8'h12);
    cyc(1, 0, 16'h03F1, 8'h55);
    rdDat(v); chk(v == 8'h00, "R2 still locked", 32'(v), 0);
    wrIdx(8'h55);
    rdDat(v); chk(v == 8'h3F, "R2 R6 unlocked reg0", 32'(v), 32'h3F);
    cyc(0, 1, 16'h03F0, 8'h00);

    // R1: register file reset contents
    for (int i = 0; i < 16; i++) begin
      wrIdx(8'(i)); rdDat(v);
      chk(v == ((i == 0) ? 8'h3F : (i == 1) ? 8'h9F : (i == 2) ? 8'hDC : 8'h00),
          "R1 reg reset", 32'(v), 32'(i));
    end

    // R7 R8 R9: address pair, parallel mode and serial selects
    for (int pair = 0; pair < 4; pair++) begin
      for (int lp = 0; lp < 4; lp++) begin
        wrIdx(8'd1); wrDat({1'b0, 2'(pair), 3'b000, 2'(lp)}); idle();
      end
      for (int sa = 0; sa < 4; sa++) begin
        for (int sb = 0; sb < 4; sb++) begin
          wrIdx(8'd2);
          wrDat({1'b0, 1'((sa + sb) & 1), 2'(sb), 1'b0, 1'(sa & 1), 2'(sa)});
          idle();
        end
      end
    end

    // R10: floppy and IDE enables
    for (int k = 0; k < 4; k++) begin
      wrIdx(8'd0); wrDat({3'b000, 1'(k >> 1), 3'b000, 1'(k & 1)}); idle();
    end

    // R4: index write and readback of upper registers
    for (int i = 3; i < 16; i++) begin
      wrIdx(8'(i)); wrDat(8'(i * 17)); rdDat(v);
      chk(v == 8'(i * 17), "R4 readback", 32'(v), 32'(i * 17));
    end
    wrIdx(8'd20); wrDat(8'hFF); rdDat(v);
    chk(v == 8'h00, "R4 R5 oob read", 32'(v), 0);
    wrIdx(8'd4); rdDat(v);
    chk(v == 8'd68, "R4 oob discard", 32'(v), 68);

    // R12: read and write in one cycle
    wrIdx(8'd5);
    cyc(1, 1, 16'h03F1, 8'hA5);
    rdDat(v); chk(v == 8'hA5, "R12 after write", 32'(v), 32'hA5);

    // R3: exit and re-entry
    wrIdx(8'hAA);
    rdDat(v); chk(v == 8'h00, "R3 locked after exit", 32'(v), 0);
    wrIdx(8'h55);
    rdDat(v); chk(v == 8'h00, "R3 one key after exit", 32'(v), 0);
    wrIdx(8'h55);
    rdDat(v); chk(v == 8'hA5, "R3 relocked then open", 32'(v), 32'hA5);

    // R11: lag on serial A enable
    wrIdx(8'd2); wrDat(8'h04); idle();
    ioWr = 1; ioAddr = 16'h03F1; ioWrData = 8'h00;
    @(posedge clk); #1;
    chk(serAEn == 1'b1, "R11 no change on write edge", 32'(serAEn), 1);
    ioWr = 0;
    @(posedge clk); #1;
    chk(serAEn == 1'b0, "R11 change next edge", 32'(serAEn), 0);
    mRegs[2] = 8'h00;
    @(negedge clk);
    idle(); idle();

    summary();
    $finish;
  end
endmodule